// File: doc/BRIEF.md
# SD Wide-Bus Write Data Block Sender

This block moves one data block from a byte-wide source onto the four data lines of an SD card that has been set to the 4-bit bus width. It is started by a one-cycle pulse and then advances only on clock cycles where the SD clock strobe `clk_en` is high. In this document such a cycle is called a tick. The block waits until the card stops holding DAT0 low. It then drives a start bit and the block's bytes as nibbles, followed by one CRC16 for each line and an end bit. After that it releases the lines, reads the card's three-bit CRC status reply from DAT0, and waits for the card's programming busy period to end.

Each line carries its own CRC. Line i receives bit 4+i and then bit i of every byte, and its CRC is computed over that serial stream alone. The surrounding controller issues the write command and keeps track of multi-block sessions. Bytes are pulled through a valid/ready handshake. When a byte is not ready, the block holds the bus and does not advance; the controller is expected to pause the SD clock during such ticks.

Top module: `sd_wide_blk_tx`

## Requirements
- R1: A `start` pulse while idle begins a block. The lines stay released (`dat_oe` low) on every tick where `dat_in[0]` is low, and the start bit is driven on the first tick where `dat_in[0]` is high.
- R2: The start bit is `dat_out` = 4'h0 with `dat_oe` high, and it is the first value presented on the bus.
- R3: `src_ready` is high only on a tick where a new byte is needed, and a byte transfers when `src_valid` and `src_ready` are both high. If `src_valid` is low on such a tick, the bus and the block's progress hold for that tick. Exactly BLOCK_BYTES bytes are taken.
- R4: Each byte goes out as two nibbles with the upper nibble first. Nibble bit 3 drives `dat_out[3]` (DAT3) and nibble bit 0 drives `dat_out[0]` (DAT0).
- R5: Line i carries a CRC16 with polynomial 0x1021 and initial value 0, computed MSB-first over that line's bit stream: bit 4+i and then bit i of each byte, in byte order.
- R6: After the last data nibble, the four CRCs are sent in parallel over 16 ticks, MSB first. One tick with `dat_out` = 4'hF follows, and on the next tick `dat_oe` goes low.
- R7: Counting the release tick as tick 0, ticks 1 to 4 are ignored. `dat_in[0]` is sampled MSB first on ticks 5, 6 and 7 to form the status token. Any token other than 3'b010 raises `crc_err`. Tick 8 is ignored.
- R8: From tick 9 after release onward, `done` pulses high for one cycle after the first tick on which `dat_in[0]` is high. `done` never rises while the card holds DAT0 low.
- R9: `crc_err` holds its value until the next block is started. Accepting `start` clears it.
- R10: During and after reset, `dat_oe`, `src_ready`, `busy`, `done` and `crc_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one block while idle |
| clk_en | input | 1 | One strobe per SD clock period (tick) |
| src_data | input | 8 | Byte from the source |
| src_valid | input | 1 | Source byte is valid |
| src_ready | output | 1 | Block takes a byte on this tick |
| dat_in | input | 4 | Sampled DAT3..DAT0 lines |
| dat_out | output | 4 | Driven DAT3..DAT0 values |
| dat_oe | output | 1 | Drive enable for all four lines |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-cycle pulse: card busy period ended |
| crc_err | output | 1 | Status token was not 3'b010 |

## Verification
The main function is tried with random bytes, all-zero bytes and all-ones bytes. The all-zero block gives four zero CRCs. The all-ones block gives four identical CRCs. Random data gives a different CRC on each line, which exposes any swap of lines or nibbles. The tick strobe and source validity are throttled at several rates, so that stalls land on both the start bit and on data nibbles. Good and bad status tokens alternate with different busy lengths before and after the block, to show that the error flag clears on a new start and that `done` follows DAT0.

// File: rtl/sd_wide_blk_tx.sv
module sd_wide_blk_tx #(
  parameter int BLOCK_BYTES = 512,
  parameter int GAP_TICKS   = 4,
  parameter logic [2:0] TOKEN_OK = 3'b010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       clk_en,
  input  logic [7:0] src_data,
  input  logic       src_valid,
  output logic       src_ready,
  input  logic [3:0] dat_in,
  output logic [3:0] dat_out,
  output logic       dat_oe,
  output logic       busy,
  output logic       done,
  output logic       crc_err
);
  localparam int CW = $clog2(BLOCK_BYTES);
  localparam logic [CW-1:0] LAST_BYTE = CW'(BLOCK_BYTES - 1);
  localparam logic [3:0] GAP_LAST = 4'(GAP_TICKS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, S_DATA, S_CRC, S_END, S_REL, S_GAP, S_TOK, S_EXTRA, S_BUSY
  } st_t;

  st_t              state;
  logic             half;
  logic [CW-1:0]    byte_cnt;
  logic [3:0]       lo_nib;
  logic [3:0][15:0] crc_q;
  logic [3:0]       bit_cnt;
  logic [2:0]       tok;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    crc_step = {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  assign busy      = (state != S_IDLE);
  assign src_ready = clk_en && (state == S_DATA) && !half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      half     <= 1'b0;
      byte_cnt <= '0;
      lo_nib   <= '0;
      crc_q    <= '0;
      bit_cnt  <= '0;
      tok      <= '0;
      dat_out  <= 4'hF;
      dat_oe   <= 1'b0;
      done     <= 1'b0;
      crc_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state    <= S_WAIT;
          crc_err  <= 1'b0;
          crc_q    <= '0;
          byte_cnt <= '0;
          half     <= 1'b0;
        end
        S_WAIT: if (clk_en && dat_in[0]) begin
          dat_oe  <= 1'b1;
          dat_out <= 4'h0;
          state   <= S_DATA;
        end
        S_DATA: if (clk_en) begin
          if (!half) begin
            if (src_valid) begin
              dat_out <= src_data[7:4];
              lo_nib  <= src_data[3:0];
              for (int i = 0; i < 4; i++) crc_q[i] <= crc_step(crc_q[i], src_data[4+i]);
              half <= 1'b1;
            end
          end else begin
            dat_out <= lo_nib;
            for (int i = 0; i < 4; i++) crc_q[i] <= crc_step(crc_q[i], lo_nib[i]);
            half     <= 1'b0;
            byte_cnt <= byte_cnt + 1'b1;
            if (byte_cnt == LAST_BYTE) begin
              state   <= S_CRC;
              bit_cnt <= '0;
            end
          end
        end
        S_CRC: if (clk_en) begin
          for (int i = 0; i < 4; i++) begin
            dat_out[i] <= crc_q[i][15];
            crc_q[i]   <= {crc_q[i][14:0], 1'b0};
          end
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == 4'd15) state <= S_END;
        end
        S_END: if (clk_en) begin
          dat_out <= 4'hF;
          state   <= S_REL;
        end
        S_REL: if (clk_en) begin
          dat_oe  <= 1'b0;
          bit_cnt <= '0;
          state   <= S_GAP;
        end
        S_GAP: if (clk_en) begin
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == GAP_LAST) begin
            bit_cnt <= '0;
            state   <= S_TOK;
          end
        end
        S_TOK: if (clk_en) begin
          tok     <= {tok[1:0], dat_in[0]};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == 4'd2) begin
            crc_err <= ({tok[1:0], dat_in[0]} != TOKEN_OK);
            state   <= S_EXTRA;
          end
        end
        S_EXTRA: if (clk_en) state <= S_BUSY;
        S_BUSY: if (clk_en && dat_in[0]) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_wait_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && clk_en && !dat_in[0]) |=> !dat_oe);
  a_r2_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_oe) |-> (dat_out == 4'h0));
  a_r3_ready_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> dat_oe);
  a_r6_end_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dat_oe) |-> ($past(dat_out) == 4'hF));
  a_r8_done_needs_dat0: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(dat_in[0]) && $past(clk_en)));
  a_r9_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_TOK && !(state == S_IDLE && start)) |=> $stable(crc_err));
endmodule

// File: tb/tb_sd_wide_blk_tx.sv
module tb_sd_wide_blk_tx;
  logic       clk = 1'b0;
  logic       rst_n, start, clk_en, src_valid;
  logic [7:0] src_data;
  logic [3:0] dat_in;
  logic       src_ready, dat_oe, busy, done, crc_err;
  logic [3:0] dat_out;

  always #4 clk = ~clk;

  sd_wide_blk_tx dut (
    .clk(clk), .rst_n(rst_n), .start(start), .clk_en(clk_en),
    .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
    .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe),
    .busy(busy), .done(done), .crc_err(crc_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] blk [512];
  logic [3:0] seen [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] c, input logic b);
    step = {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  function automatic logic [15:0] line_crc(input int ln);
    logic [15:0] c = 16'h0;
    for (int j = 0; j < 512; j++) begin
      c = step(c, blk[j][4+ln]);
      c = step(c, blk[j][ln]);
    end
    return c;
  endfunction

  task automatic run_block(input int pre_busy, input int post_busy, input logic [2:0] token,
                           input int en_pct, input int valid_pct);
    int idx = 0, phase = 0, k = 0, left = pre_busy, pleft = post_busy, cyc = 0;
    bit exp_done = 0, got_done = 0, saw_hi = 0, en;
    logic d0 = 1'b1;
    logic [15:0] lc [4];
    seen.delete();
    @(negedge clk);
    clk_en = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    chk(crc_err == 1'b0, "R9 err cleared by start", crc_err, 0);
    while (cyc < 20000) begin
      if (exp_done) begin
        chk(done == 1'b1, "R8 done after DAT0 high", done, 1);
        got_done = 1;
        break;
      end
      if (done) chk(1'b0, "R8 early done", 1, 0);
      if (phase == 0 && dat_oe) begin
        phase = 1;
        chk(saw_hi, "R1 drive only after DAT0 high", 0, 1);
      end
      if (phase == 1 && !dat_oe) phase = 2;
      en = ($urandom_range(99) < en_pct);
      clk_en = en;
      src_valid = ($urandom_range(99) < valid_pct);
      src_data = (idx < 512) ? blk[idx] : 8'h00;
      if (en) begin
        case (phase)
          0: begin
            if (left > 0) begin d0 = 1'b0; left--; end
            else begin d0 = 1'b1; saw_hi = 1; end
          end
          1: d0 = 1'b1;
          default: begin
            k++;
            if (k >= 5 && k <= 7) d0 = token[7-k];
            else if (k == 8) d0 = 1'($urandom_range(1));
            else if (k >= 9) begin
              if (pleft > 0) begin d0 = 1'b0; pleft--; end
              else begin d0 = 1'b1; exp_done = 1; end
            end else d0 = 1'b1;
          end
        endcase
      end
      dat_in = {3'b111, d0};
      #1;
      if (en && phase == 1) begin
        if (!(src_ready && !src_valid)) seen.push_back(dat_out);
        if (src_ready && src_valid) idx++;
      end
      if (!dat_oe && src_ready) chk(1'b0, "R3 ready off bus", 1, 0);
      @(negedge clk);
      cyc++;
    end
    clk_en = 1'b0;
    dat_in = 4'hF;
    chk(got_done, "R8 watchdog block end", 0, 1);
    chk(idx == 512, "R3 bytes taken", idx, 512);
    chk(seen.size() == 1042, "R6 bus length", seen.size(), 1042);
    if (seen.size() == 1042) begin
      chk(seen[0] == 4'h0, "R2 start bit", seen[0], 0);
      for (int j = 0; j < 512; j++) begin
        chk(seen[1+2*j] == blk[j][7:4], "R4 upper nibble", seen[1+2*j], blk[j][7:4]);
        chk(seen[2+2*j] == blk[j][3:0], "R4 lower nibble", seen[2+2*j], blk[j][3:0]);
      end
      for (int ln = 0; ln < 4; ln++) lc[ln] = line_crc(ln);
      for (int b = 0; b < 16; b++) begin
        logic [3:0] e;
        for (int ln = 0; ln < 4; ln++) e[ln] = lc[ln][15-b];
        chk(seen[1025+b] == e, "R5 line crc bits", seen[1025+b], e);
      end
      chk(seen[1041] == 4'hF, "R6 end bit", seen[1041], 15);
    end
    chk(crc_err == (token != 3'b010), "R7 token result", crc_err, token != 3'b010);
    repeat (5) @(negedge clk);
    chk(crc_err == (token != 3'b010), "R9 err held", crc_err, token != 3'b010);
    chk(busy == 1'b0 && done == 1'b0, "R8 idle after done", {busy, done}, 0);
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; clk_en = 1'b1; src_valid = 1'b1;
    src_data = 8'h00; dat_in = 4'hF;
    repeat (3) @(negedge clk);
    chk(!dat_oe && !src_ready && !busy && !done && !crc_err, "R10 reset state",
        {dat_oe, src_ready, busy, done, crc_err}, 0);
    rst_n = 1'b1;
    clk_en = 1'b0;
    @(negedge clk);
    chk(!dat_oe && !busy && !crc_err, "R10 after reset", {dat_oe, busy, crc_err}, 0);

    for (int j = 0; j < 512; j++) blk[j] = 8'($urandom);
    run_block(3, 6, 3'b010, 60, 70);
    for (int j = 0; j < 512; j++) blk[j] = 8'h00;
    run_block(0, 0, 3'b101, 100, 100);
    for (int j = 0; j < 512; j++) blk[j] = 8'hFF;
    run_block(5, 2, 3'b010, 100, 50);
    for (int j = 0; j < 512; j++) blk[j] = 8'($urandom);
    run_block(2, 3, 3'b011, 40, 90);
    for (int j = 0; j < 512; j++) blk[j] = 8'(j * 37 + 5);
    run_block(1, 1, 3'b010, 100, 100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule